// File: doc/BRIEF.md
# Time Base and Decrementer

This block keeps a free-running 64-bit time base and a 32-bit signed decrementer. Both move on a single tick-enable input: each tick adds one to the time base and subtracts one from the decrementer. Software loads either half of the time base, the decrementer, or a coarse real-time-clock view of the lower time-base word through separate write strobes sharing one data bus. All current values are presented continuously on output ports.

The decrementer drives a single level interrupt request. The request is set when a tick takes the decrementer from zero to all ones. It is also set when a software write stores a negative value while the current value is non-negative. Once set, it stays asserted until the clear input is pulsed.

Top module: `tbd_unit`

## Requirements
- R1: During and after reset the time base reads zero in both halves, the decrementer reads 0xFFFFFFFF and the interrupt request is low.
- R2: With `tick_en` high and no write strobe, the 64-bit time base increases by one in the next cycle, and a carry out of the lower half reaches the upper half in that same cycle.
- R3: With `tick_en` low and no write strobe, the time base and the decrementer keep their values.
- R4: A write to the upper half loads it from `wr_data` and leaves the lower half unchanged, even if a tick arrives in the same cycle.
- R5: A write to the lower half loads it from `wr_data` and leaves the upper half unchanged, even if a tick arrives in the same cycle.
- R6: Each tick lowers the decrementer by one, and it keeps counting below zero in two's complement.
- R7: A tick that takes the decrementer from 0 to 0xFFFFFFFF sets the interrupt request.
- R8: A decrementer write sets the interrupt request only when bit 31 of `wr_data` is 1 and bit 31 of the current decrementer value is 0.
- R9: When a decrementer write and a tick fall in the same cycle, the decrementer takes the written value.
- R10: The interrupt request stays high until `irq_clr` is pulsed, and a new set in the same cycle as a clear leaves it high.
- R11: `rtc_lo` shows the lower time-base word ANDed with 0x3FFFFF80. A real-time-clock write changes only the lower-word bits inside that mask and leaves every other bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base tick enable |
| wr_tb_hi | input | 1 | Write strobe, upper time-base half |
| wr_tb_lo | input | 1 | Write strobe, lower time-base half |
| wr_rtc | input | 1 | Write strobe, masked real-time-clock view |
| wr_dec | input | 1 | Write strobe, decrementer |
| wr_data | input | 32 | Write data |
| irq_clr | input | 1 | Clears the pending interrupt |
| tb_hi | output | 32 | Upper time-base half |
| tb_lo | output | 32 | Lower time-base half |
| rtc_lo | output | 32 | Masked real-time-clock view |
| dec_val | output | 32 | Decrementer value |
| dec_irq | output | 1 | Pending decrementer interrupt |

## Verification
The hardest case to reach is the interrupt raised by a write, because it depends on the sign of the decrementer at the moment of the write. The bench first steers the decrementer to a known sign with ordinary writes and ticks. It then writes negative values, once with the current value negative and once with it positive, and it also combines such a write with a clear in the same cycle. The carry into the upper half needs the lower half at all ones, so the bench loads a value just below that before ticking.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int unsigned TBD_HALF_W = 32;
  localparam int unsigned TBD_DEC_W  = 32;
  localparam logic [31:0] TBD_RTC_MASK = 32'h3FFF_FF80;

  typedef enum logic [1:0] {
    DEC_HOLD  = 2'd0,
    DEC_STEP  = 2'd1,
    DEC_LOAD  = 2'd2
  } dec_op_e;
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
  parameter int unsigned HALF_W = 32,
  parameter logic [HALF_W-1:0] RTC_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              wr_rtc,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] hi_q,
  output logic [HALF_W-1:0] lo_q
);
  localparam logic [2*HALF_W-1:0] ONE_W = {{(2*HALF_W-1){1'b0}}, 1'b1};
  localparam logic [HALF_W-1:0]   ONE_H = {{(HALF_W-1){1'b0}}, 1'b1};

  logic              wr_any;
  logic              load_en;
  logic [HALF_W-1:0] hi_n;
  logic [HALF_W-1:0] lo_n;
  logic [HALF_W-1:0] rtc_merged;
  logic [2*HALF_W-1:0] sum;

  // Per-bit merge for the masked clock view: masked bits take data.
  for (genvar b = 0; b < HALF_W; b++) begin : g_rtc_bit
    if (RTC_MASK[b]) begin : g_take
      assign rtc_merged[b] = wdata[b];
    end else begin : g_keep
      assign rtc_merged[b] = lo_q[b];
    end
  end

  assign wr_any  = wr_hi | wr_lo | wr_rtc;
  assign load_en = wr_any | tick;
  assign sum     = {hi_q, lo_q} + ONE_W;

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (wr_any) begin
      if (wr_hi) hi_n = wdata;
      if (wr_lo) lo_n = wdata;
      else if (wr_rtc) lo_n = rtc_merged;
    end else if (tick) begin
      {hi_n, lo_n} = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_en) begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  a_r2_carry_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_any && lo_q == '1) |=> (lo_q == '0 && hi_q == $past(hi_q) + ONE_H));
  a_r4_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo && !wr_rtc) |=> (lo_q == $past(lo_q) && hi_q == $past(wdata)));
  a_r5_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> (hi_q == $past(hi_q) && lo_q == $past(wdata)));
  a_r3_tb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_any) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/tbd_decr.sv
module tbd_decr
  import tbd_pkg::*;
#(
  parameter int unsigned DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [DEC_W-1:0] wdata,
  output logic [DEC_W-1:0] dec_q,
  output logic             fire
);
  localparam int unsigned MSB = DEC_W - 1;
  localparam logic [DEC_W-1:0] ONE = {{(DEC_W-1){1'b0}}, 1'b1};

  dec_op_e          op;
  logic [DEC_W-1:0] dec_n;

  always_comb begin
    if (wr)        op = DEC_LOAD;
    else if (tick) op = DEC_STEP;
    else           op = DEC_HOLD;
  end

  always_comb begin
    dec_n = dec_q;
    fire  = 1'b0;
    case (op)
      DEC_LOAD: begin
        dec_n = wdata;
        fire  = wdata[MSB] & ~dec_q[MSB];
      end
      DEC_STEP: begin
        dec_n = dec_q - ONE;
        fire  = (dec_q == '0);
      end
      default: begin
        dec_n = dec_q;
        fire  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dec_q <= '1;
    else if (op != DEC_HOLD) dec_q <= dec_n;
  end

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (dec_q == $past(wdata)));
  a_r6_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr) |=> (dec_q == $past(dec_q) - ONE));
  a_r3_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(dec_q));
endmodule

// File: rtl/tbd_irq.sv
module tbd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_n;
  logic upd;

  assign upd = set | clr;

  always_comb begin
    if (set)      pend_n = 1'b1;
    else if (clr) pend_n = 1'b0;
    else          pend_n = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (upd) pend <= pend_n;
  end

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend);
endmodule

// File: rtl/tbd_unit.sv
module tbd_unit
  import tbd_pkg::*;
#(
  parameter int unsigned HALF_W = TBD_HALF_W,
  parameter int unsigned DEC_W  = TBD_DEC_W,
  parameter logic [HALF_W-1:0] RTC_MASK = TBD_RTC_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_tb_hi,
  input  logic              wr_tb_lo,
  input  logic              wr_rtc,
  input  logic              wr_dec,
  input  logic [31:0]       wr_data,
  input  logic              irq_clr,
  output logic [HALF_W-1:0] tb_hi,
  output logic [HALF_W-1:0] tb_lo,
  output logic [HALF_W-1:0] rtc_lo,
  output logic [DEC_W-1:0]  dec_val,
  output logic              dec_irq
);
  logic dec_fire;

  tbd_timebase #(
    .HALF_W  (HALF_W),
    .RTC_MASK(RTC_MASK)
  ) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_en),
    .wr_hi (wr_tb_hi),
    .wr_lo (wr_tb_lo),
    .wr_rtc(wr_rtc),
    .wdata (wr_data[HALF_W-1:0]),
    .hi_q  (tb_hi),
    .lo_q  (tb_lo)
  );

  tbd_decr #(
    .DEC_W(DEC_W)
  ) u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_en),
    .wr   (wr_dec),
    .wdata(wr_data[DEC_W-1:0]),
    .dec_q(dec_val),
    .fire (dec_fire)
  );

  tbd_irq u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (dec_fire),
    .clr  (irq_clr),
    .pend (dec_irq)
  );

  assign rtc_lo = tb_lo & RTC_MASK;

  a_r7_wrap_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_dec && dec_val == '0) |=> dec_irq);
  a_r8_write_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dec && wr_data[DEC_W-1] && !dec_val[DEC_W-1]) |=> dec_irq);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_irq && wr_dec && !(wr_data[DEC_W-1] && !dec_val[DEC_W-1])) |=> !dec_irq);
  a_r11_rtc_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rtc && !wr_tb_lo) |=> ((tb_lo & ~RTC_MASK) == ($past(tb_lo) & ~RTC_MASK)));
endmodule

// File: tb/tbd_unit_tb.sv
module tbd_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        tick_en, wr_tb_hi, wr_tb_lo, wr_rtc, wr_dec, irq_clr;
  logic [31:0] wr_data;
  logic [31:0] tb_hi, tb_lo, rtc_lo, dec_val;
  logic        dec_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tbd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_tb_hi(wr_tb_hi),
    .wr_tb_lo(wr_tb_lo), .wr_rtc(wr_rtc), .wr_dec(wr_dec), .wr_data(wr_data),
    .irq_clr(irq_clr), .tb_hi(tb_hi), .tb_lo(tb_lo), .rtc_lo(rtc_lo),
    .dec_val(dec_val), .dec_irq(dec_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle from a negedge; returns at the following negedge.
  task automatic cyc(input bit t, input bit whi, input bit wlo, input bit wrtc,
                     input bit wd, input bit clr, input logic [31:0] d);
    tick_en = t; wr_tb_hi = whi; wr_tb_lo = wlo; wr_rtc = wrtc;
    wr_dec = wd; irq_clr = clr; wr_data = d;
    @(negedge clk);
    tick_en = 0; wr_tb_hi = 0; wr_tb_lo = 0; wr_rtc = 0;
    wr_dec = 0; irq_clr = 0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 tb_hi", tb_hi, 32'h0);
    chk("R1 tb_lo", tb_lo, 32'h0);
    chk("R1 dec", dec_val, 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, dec_irq}, 32'h0);
  endtask

  task automatic t_tick_basic;
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0, '0);
    chk("R2 lo after 5 ticks", tb_lo, 32'd5);
    chk("R6 dec after 5 ticks", dec_val, 32'hFFFF_FFFA);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, '0);
    chk("R3 lo held", tb_lo, 32'd5);
    chk("R3 dec held", dec_val, 32'hFFFF_FFFA);
  endtask

  task automatic t_carry;
    cyc(0, 0, 1, 0, 0, 0, 32'hFFFF_FFFE);
    cyc(0, 1, 0, 0, 0, 0, 32'h0000_0012);
    chk("R5 lo loaded", tb_lo, 32'hFFFF_FFFE);
    chk("R4 hi loaded", tb_hi, 32'h12);
    cyc(1, 0, 0, 0, 0, 0, '0);
    cyc(1, 0, 0, 0, 0, 0, '0);
    chk("R2 carry lo", tb_lo, 32'h0);
    chk("R2 carry hi", tb_hi, 32'h13);
    cyc(1, 1, 0, 0, 0, 0, 32'h0000_AAAA);
    chk("R4 hi write with tick", tb_hi, 32'hAAAA);
    chk("R4 lo unchanged", tb_lo, 32'h0);
    cyc(1, 0, 1, 0, 0, 0, 32'h0000_0055);
    chk("R5 lo write with tick", tb_lo, 32'h55);
    chk("R5 hi unchanged", tb_hi, 32'hAAAA);
  endtask

  task automatic t_dec_wrap;
    cyc(0, 0, 0, 0, 1, 0, 32'd2);
    chk("R8 positive write no irq", {31'b0, dec_irq}, 32'h0);
    cyc(1, 0, 0, 0, 0, 0, '0);
    cyc(1, 0, 0, 0, 0, 0, '0);
    chk("R6 dec reaches zero", dec_val, 32'h0);
    chk("R7 no irq at zero", {31'b0, dec_irq}, 32'h0);
    cyc(1, 0, 0, 0, 0, 0, '0);
    chk("R6 dec negative", dec_val, 32'hFFFF_FFFF);
    chk("R7 irq on wrap", {31'b0, dec_irq}, 32'h1);
    cyc(1, 0, 0, 0, 0, 0, '0);
    chk("R10 irq stays", {31'b0, dec_irq}, 32'h1);
    cyc(0, 0, 0, 0, 0, 1, '0);
    chk("R10 irq cleared", {31'b0, dec_irq}, 32'h0);
    chk("R3 dec held on clear", dec_val, 32'hFFFF_FFFE);
  endtask

  task automatic t_dec_write_fire;
    cyc(0, 0, 0, 0, 1, 0, 32'h8000_0000);
    chk("R8 neg over neg no irq", {31'b0, dec_irq}, 32'h0);
    cyc(0, 0, 0, 0, 1, 0, 32'h0000_0010);
    chk("R8 pos over neg no irq", {31'b0, dec_irq}, 32'h0);
    cyc(0, 0, 0, 0, 1, 0, 32'h8000_0005);
    chk("R8 neg over pos irq", {31'b0, dec_irq}, 32'h1);
    chk("R8 dec loaded", dec_val, 32'h8000_0005);
    cyc(0, 0, 0, 0, 0, 1, '0);
    cyc(1, 0, 0, 0, 1, 0, 32'h0000_0100);
    chk("R9 write beats tick", dec_val, 32'h100);
    chk("R9 no irq", {31'b0, dec_irq}, 32'h0);
    cyc(0, 0, 0, 0, 1, 1, 32'hF000_0000);
    chk("R10 set beats clear", {31'b0, dec_irq}, 32'h1);
    cyc(0, 0, 0, 0, 0, 1, '0);
  endtask

  task automatic t_rtc;
    cyc(0, 0, 1, 0, 0, 0, 32'hC000_007F);
    chk("R11 rtc view zero", rtc_lo, 32'h0);
    cyc(0, 0, 0, 1, 0, 0, 32'hFFFF_FFFF);
    chk("R11 lo after rtc write", tb_lo, 32'hFFFF_FFFF);
    chk("R11 rtc view", rtc_lo, 32'h3FFF_FF80);
    cyc(0, 0, 0, 1, 0, 0, 32'h0000_0000);
    chk("R11 lo outside mask kept", tb_lo, 32'hC000_007F);
    chk("R11 rtc view cleared", rtc_lo, 32'h0);
  endtask

  initial begin
    rst_n = 0; tick_en = 0; wr_tb_hi = 0; wr_tb_lo = 0; wr_rtc = 0;
    wr_dec = 0; irq_clr = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tick_basic();
    t_carry();
    t_dec_wrap();
    t_dec_write_fire();
    t_rtc();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule